// File: doc/BRIEF.md
# Register Writer-Queue Scoreboard

This block keeps track, for one hardware thread, of which in-flight instructions still owe a result to each architectural register. A flat register index is mapped onto one of three classes (integer, floating-point, miscellaneous). Each register owns a short queue of pending writer sequence numbers, held oldest first. The issue logic uses it in four ways. It enqueues an instruction's destinations at dispatch. It asks, for each source operand, whether the value may come from the register file, from a forwarding producer, or whether the reader must stall. It asks permission before writing back, and a granted write retires the queue head. It deletes a particular writer from a register's queue when that writer is cancelled.

Dispatch is a valid/ready stream. An instruction is taken on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is computed from the presented destinations alone and never from `disp_valid`. It drops while any enabled, in-range destination queue is full. A producer holds its payload stable until it is taken. The read, write, remove and done ports are plain per-cycle strobes with combinational answers. The queue updates they cause take effect at the next rising clock edge.

Sequence numbers are compared modulo 2^SEQ_W, so age order survives counter rollover. A separate done port marks a queued writer as having produced its result. Only a marked producer can forward.

Top module: `regdep_scoreboard`

## Requirements
- R1: Index decode (defaults): indices 0..7 are integer registers, 8..15 are floating-point registers (local index = idx-8), and 16..19 are miscellaneous registers (local index = idx-16). Queues of different registers are independent.
- R2: An accepted dispatch (`disp_valid` and `disp_ready` high at a rising edge) appends `disp_seq` to the queue of every enabled destination lane. Two lanes naming the same register append one entry.
- R3: `disp_ready` is low while any enabled, in-range destination queue holds DEPTH (4) entries. A dispatch that is not taken changes no queue.
- R4: `rd_from_rf` is high when `rd_valid` is high, the register's queue is empty or `rd_seq` is the same age as or older than the queue head. All read outputs are low when `rd_valid` is low.
- R5: When the register file cannot serve the read, the forwarding candidate is the youngest queued writer older than `rd_seq`. If that writer is marked done, `rd_fwd` is high and `rd_fwd_seq` carries its sequence number.
- R6: `rd_stall` is high when a valid, in-range read gets neither the register file nor a forward. At most one of `rd_from_rf`, `rd_fwd` and `rd_stall` is high.
- R7: `wr_grant` is high when `wr_valid` is high, the index is in range and the queue is empty or `wr_seq` is the same age as or older than the head.
- R8: A granted write whose `wr_seq` equals the head pops the head at the next edge. A granted write to a non-empty queue whose head differs leaves the queue unchanged and sets the sticky `err_order` flag.
- R9: A remove strobe deletes only the first entry of the register's queue whose tag equals `rm_seq`. Later entries keep their order. With no match, nothing changes.
- R10: All age comparisons are modulo 2^SEQ_W: a is older than b when (a-b) mod 2^SEQ_W has its top bit set.
- R11: An index outside the three classes (20..31 by default) on any strobed port sets the sticky `err_bad_idx` flag and updates no queue. A dispatch carrying such a lane is still taken, but appends nothing for any lane.
- R12: A done strobe marks the queued entry of `done_idx` whose tag equals `done_seq` as done. New entries start not-done.
- R13: After reset all queues are empty, `disp_ready` is high and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Dispatch request valid |
| disp_ready | output | 1 | Dispatch can be taken |
| disp_seq | input | SEQ_W | Sequence number of dispatched instruction |
| disp_dst_en | input | DST_N | Per-lane destination enable |
| disp_dst | input | DST_N*IDX_W | Per-lane flat destination index, lane 0 in low bits |
| done_valid | input | 1 | Producer result-ready strobe |
| done_idx | input | IDX_W | Register of the finished producer |
| done_seq | input | SEQ_W | Sequence number of the finished producer |
| rd_valid | input | 1 | Read query valid |
| rd_idx | input | IDX_W | Source register index |
| rd_seq | input | SEQ_W | Reader sequence number |
| rd_from_rf | output | 1 | Source may be read from the register file |
| rd_fwd | output | 1 | Source may be forwarded |
| rd_fwd_seq | output | SEQ_W | Sequence number of the forwarding producer |
| rd_stall | output | 1 | Reader must retry later |
| wr_valid | input | 1 | Write query valid |
| wr_idx | input | IDX_W | Destination register index |
| wr_seq | input | SEQ_W | Writer sequence number |
| wr_grant | output | 1 | Write may proceed |
| rm_valid | input | 1 | Remove strobe |
| rm_idx | input | IDX_W | Register to remove from |
| rm_seq | input | SEQ_W | Tag to remove |
| err_bad_idx | output | 1 | Sticky out-of-range index flag |
| err_order | output | 1 | Sticky write-head mismatch flag |

## Verification
The bench queues several writers on one register and reads with reader tags placed between them. A design that picked the oldest older writer, instead of the youngest, would forward the wrong tag. It removes a writer from the middle of a queue and then reads with a tag just past the removed one. A design that removed the wrong entry or broke the order would forward a different tag. It fills a queue and holds a dispatch against it; a design that leaked the rejected entry would change a later forward into a stall. It also drives tags across the rollover point and issues out-of-order and out-of-range writes. A plain magnitude compare, a pop without the head check, or an update on a bad index would each give a wrong grant or a wrong read result at the ports.

// File: rtl/regdep_pkg.sv
package regdep_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } reg_class_e;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_RF    = 2'd1,
    RD_FWD   = 2'd2,
    RD_STALL = 2'd3
  } rd_result_e;
endpackage

// File: rtl/regdep_decode.sv
module regdep_decode
  import regdep_pkg::*;
#(
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned FP_BASE   = 8,
  parameter int unsigned CTRL_BASE = 16,
  parameter int unsigned N_INT     = 8,
  parameter int unsigned N_FP      = 8,
  parameter int unsigned N_MISC    = 4,
  parameter int unsigned QID_W     = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [QID_W-1:0] qid,
  output logic             ok
);
  reg_class_e  cls;
  int unsigned v;
  int unsigned loc;
  int unsigned base;

  always_comb begin
    v = 32'(idx);
    if (v < FP_BASE) begin
      cls = CLS_INT;
      loc = v;
    end else if (v < CTRL_BASE) begin
      cls = CLS_FP;
      loc = v - FP_BASE;
    end else begin
      cls = CLS_MISC;
      loc = v - CTRL_BASE;
    end
    case (cls)
      CLS_INT:  begin ok = (loc < N_INT);  base = 0;            end
      CLS_FP:   begin ok = (loc < N_FP);   base = N_INT;        end
      default:  begin ok = (loc < N_MISC); base = N_INT + N_FP; end
    endcase
    qid = ok ? QID_W'(base + loc) : '0;
  end
endmodule

// File: rtl/regdep_queue.sv
module regdep_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mark,
  input  logic [SEQ_W-1:0]       mark_seq,
  input  logic                   pop,
  input  logic                   rm,
  input  logic [SEQ_W-1:0]       rm_seq,
  input  logic                   push,
  input  logic [SEQ_W-1:0]       push_seq,
  output logic [CNT_W-1:0]       cnt,
  output logic [DEPTH*SEQ_W-1:0] ent_seq,
  output logic [DEPTH-1:0]       ent_done
);
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [CNT_W-1:0] cnt_q;

  logic [SEQ_W-1:0] seq_n [DEPTH];
  logic [DEPTH-1:0] done_n;
  logic [CNT_W-1:0] cnt_n;
  logic             rm_hit;
  int unsigned      rm_pos;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) seq_n[i] = seq_q[i];
    done_n = done_q;
    cnt_n  = cnt_q;
    rm_hit = 1'b0;
    rm_pos = 0;

    // result-ready marking on the current contents
    if (mark) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) < cnt_n && seq_n[i] == mark_seq) done_n[i] = 1'b1;
    end

    // retire head
    if (pop && cnt_n != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        seq_n[i]  = seq_n[i+1];
        done_n[i] = done_n[i+1];
      end
      seq_n[DEPTH-1]  = '0;
      done_n[DEPTH-1] = 1'b0;
      cnt_n = cnt_n - 1'b1;
    end

    // delete first matching tag
    if (rm) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!rm_hit && CNT_W'(i) < cnt_n && seq_n[i] == rm_seq) begin
          rm_hit = 1'b1;
          rm_pos = i;
        end
      end
      if (rm_hit) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (i >= rm_pos) begin
            seq_n[i]  = seq_n[i+1];
            done_n[i] = done_n[i+1];
          end
        end
        seq_n[DEPTH-1]  = '0;
        done_n[DEPTH-1] = 1'b0;
        cnt_n = cnt_n - 1'b1;
      end
    end

    // append at tail
    if (push && cnt_n < CNT_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_n) begin
          seq_n[i]  = push_seq;
          done_n[i] = 1'b0;
        end
      end
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
      done_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= seq_n[i];
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  assign cnt      = cnt_q;
  assign ent_done = done_q;
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign ent_seq[g*SEQ_W +: SEQ_W] = seq_q[g];
    end
  endgenerate
endmodule

// File: rtl/regdep_fwd_pick.sv
module regdep_fwd_pick #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic [CNT_W-1:0]       cnt,
  input  logic [DEPTH*SEQ_W-1:0] ent_seq,
  input  logic [DEPTH-1:0]       ent_done,
  input  logic [SEQ_W-1:0]       rd_seq,
  output logic                   found,
  output logic [SEQ_W-1:0]       pick_seq,
  output logic                   pick_done
);
  function automatic logic seq_lt(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic scanning;

  always_comb begin
    found     = 1'b0;
    pick_seq  = '0;
    pick_done = 1'b0;
    scanning  = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (scanning && CNT_W'(i) < cnt && seq_lt(ent_seq[i*SEQ_W +: SEQ_W], rd_seq)) begin
        found     = 1'b1;
        pick_seq  = ent_seq[i*SEQ_W +: SEQ_W];
        pick_done = ent_done[i];
      end else begin
        scanning = 1'b0;
      end
    end
  end
endmodule

// File: rtl/regdep_scoreboard.sv
module regdep_scoreboard
  import regdep_pkg::*;
#(
  parameter int unsigned SEQ_W     = 8,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned FP_BASE   = 8,
  parameter int unsigned CTRL_BASE = 16,
  parameter int unsigned N_INT     = 8,
  parameter int unsigned N_FP      = 8,
  parameter int unsigned N_MISC    = 4,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned DST_N     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [SEQ_W-1:0]       disp_seq,
  input  logic [DST_N-1:0]       disp_dst_en,
  input  logic [DST_N*IDX_W-1:0] disp_dst,
  input  logic                   done_valid,
  input  logic [IDX_W-1:0]       done_idx,
  input  logic [SEQ_W-1:0]       done_seq,
  input  logic                   rd_valid,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [SEQ_W-1:0]       rd_seq,
  output logic                   rd_from_rf,
  output logic                   rd_fwd,
  output logic [SEQ_W-1:0]       rd_fwd_seq,
  output logic                   rd_stall,
  input  logic                   wr_valid,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [SEQ_W-1:0]       wr_seq,
  output logic                   wr_grant,
  input  logic                   rm_valid,
  input  logic [IDX_W-1:0]       rm_idx,
  input  logic [SEQ_W-1:0]       rm_seq,
  output logic                   err_bad_idx,
  output logic                   err_order
);
  localparam int unsigned N_Q   = N_INT + N_FP + N_MISC;
  localparam int unsigned QID_W = (N_Q > 1) ? $clog2(N_Q) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  function automatic logic seq_le(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1] || (d == '0);
  endfunction

  // per-queue state views
  logic [CNT_W-1:0]       q_cnt  [N_Q];
  logic [DEPTH*SEQ_W-1:0] q_seq  [N_Q];
  logic [DEPTH-1:0]       q_done [N_Q];

  // decodes
  logic [QID_W-1:0] lane_qid [DST_N];
  logic [DST_N-1:0] lane_ok;
  logic [QID_W-1:0] rd_qid, wr_qid, rm_qid, dn_qid;
  logic             rd_ok, wr_ok, rm_ok, dn_ok;

  generate
    for (genvar l = 0; l < DST_N; l++) begin : g_lane
      regdep_decode #(
        .IDX_W(IDX_W), .FP_BASE(FP_BASE), .CTRL_BASE(CTRL_BASE),
        .N_INT(N_INT), .N_FP(N_FP), .N_MISC(N_MISC), .QID_W(QID_W)
      ) u_dec (
        .idx(disp_dst[l*IDX_W +: IDX_W]), .qid(lane_qid[l]), .ok(lane_ok[l])
      );
    end
  endgenerate

  regdep_decode #(
    .IDX_W(IDX_W), .FP_BASE(FP_BASE), .CTRL_BASE(CTRL_BASE),
    .N_INT(N_INT), .N_FP(N_FP), .N_MISC(N_MISC), .QID_W(QID_W)
  ) u_dec_rd (.idx(rd_idx), .qid(rd_qid), .ok(rd_ok));

  regdep_decode #(
    .IDX_W(IDX_W), .FP_BASE(FP_BASE), .CTRL_BASE(CTRL_BASE),
    .N_INT(N_INT), .N_FP(N_FP), .N_MISC(N_MISC), .QID_W(QID_W)
  ) u_dec_wr (.idx(wr_idx), .qid(wr_qid), .ok(wr_ok));

  regdep_decode #(
    .IDX_W(IDX_W), .FP_BASE(FP_BASE), .CTRL_BASE(CTRL_BASE),
    .N_INT(N_INT), .N_FP(N_FP), .N_MISC(N_MISC), .QID_W(QID_W)
  ) u_dec_rm (.idx(rm_idx), .qid(rm_qid), .ok(rm_ok));

  regdep_decode #(
    .IDX_W(IDX_W), .FP_BASE(FP_BASE), .CTRL_BASE(CTRL_BASE),
    .N_INT(N_INT), .N_FP(N_FP), .N_MISC(N_MISC), .QID_W(QID_W)
  ) u_dec_dn (.idx(done_idx), .qid(dn_qid), .ok(dn_ok));

  // dispatch stream
  logic [DST_N-1:0] lane_full, lane_bad;
  logic             disp_fire, disp_update;

  always_comb begin
    for (int l = 0; l < DST_N; l++) begin
      lane_bad[l]  = disp_dst_en[l] && !lane_ok[l];
      lane_full[l] = disp_dst_en[l] && lane_ok[l] &&
                     (q_cnt[lane_ok[l] ? lane_qid[l] : '0] == CNT_W'(DEPTH));
    end
  end

  assign disp_ready  = ~|lane_full;
  assign disp_fire   = disp_valid && disp_ready;
  assign disp_update = disp_fire && ~|lane_bad;

  // write-back query
  logic [QID_W-1:0] wr_sel;
  logic [SEQ_W-1:0] wr_head;
  logic             wr_empty, wr_pop, wr_mismatch;

  assign wr_sel      = wr_ok ? wr_qid : '0;
  assign wr_head     = q_seq[wr_sel][SEQ_W-1:0];
  assign wr_empty    = (q_cnt[wr_sel] == '0);
  assign wr_grant    = wr_valid && wr_ok && (wr_empty || seq_le(wr_seq, wr_head));
  assign wr_pop      = wr_grant && !wr_empty && (wr_head == wr_seq);
  assign wr_mismatch = wr_grant && !wr_empty && (wr_head != wr_seq);

  // queue array
  generate
    for (genvar q = 0; q < N_Q; q++) begin : g_q
      logic push_q;
      always_comb begin
        push_q = 1'b0;
        for (int l = 0; l < DST_N; l++)
          if (disp_dst_en[l] && lane_ok[l] && lane_qid[l] == QID_W'(q)) push_q = 1'b1;
        push_q = push_q && disp_update;
      end

      regdep_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .mark     (done_valid && dn_ok && dn_qid == QID_W'(q)),
        .mark_seq (done_seq),
        .pop      (wr_pop && wr_qid == QID_W'(q)),
        .rm       (rm_valid && rm_ok && rm_qid == QID_W'(q)),
        .rm_seq   (rm_seq),
        .push     (push_q),
        .push_seq (disp_seq),
        .cnt      (q_cnt[q]),
        .ent_seq  (q_seq[q]),
        .ent_done (q_done[q])
      );
    end
  endgenerate

  // read query
  logic [QID_W-1:0] rd_sel;
  logic             fwd_found, fwd_done, rd_rf_ok;
  logic [SEQ_W-1:0] fwd_seq;
  rd_result_e       rd_res;

  assign rd_sel = rd_ok ? rd_qid : '0;

  regdep_fwd_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_pick (
    .cnt       (q_cnt[rd_sel]),
    .ent_seq   (q_seq[rd_sel]),
    .ent_done  (q_done[rd_sel]),
    .rd_seq    (rd_seq),
    .found     (fwd_found),
    .pick_seq  (fwd_seq),
    .pick_done (fwd_done)
  );

  assign rd_rf_ok = (q_cnt[rd_sel] == '0) || seq_le(rd_seq, q_seq[rd_sel][SEQ_W-1:0]);

  always_comb begin
    if (!rd_valid || !rd_ok)       rd_res = RD_NONE;
    else if (rd_rf_ok)             rd_res = RD_RF;
    else if (fwd_found && fwd_done) rd_res = RD_FWD;
    else                           rd_res = RD_STALL;
  end

  assign rd_from_rf = (rd_res == RD_RF);
  assign rd_fwd     = (rd_res == RD_FWD);
  assign rd_stall   = (rd_res == RD_STALL);
  assign rd_fwd_seq = (rd_res == RD_FWD) ? fwd_seq : '0;

  // sticky error flags
  logic bad_now;
  assign bad_now = (disp_fire && |lane_bad) || (rd_valid && !rd_ok) ||
                   (wr_valid && !wr_ok) || (rm_valid && !rm_ok) ||
                   (done_valid && !dn_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_bad_idx <= 1'b0;
      err_order   <= 1'b0;
    end else begin
      if (bad_now)     err_bad_idx <= 1'b1;
      if (wr_mismatch) err_order   <= 1'b1;
    end
  end
endmodule

// File: rtl/regdep_scoreboard_chk.sv
module regdep_scoreboard_chk #(
  parameter int unsigned SEQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic [SEQ_W-1:0] rd_seq,
  input logic             rd_from_rf,
  input logic             rd_fwd,
  input logic [SEQ_W-1:0] rd_fwd_seq,
  input logic             rd_stall,
  input logic             wr_valid,
  input logic             wr_grant,
  input logic             err_bad_idx,
  input logic             err_order
);
  logic [SEQ_W-1:0] fwd_diff;
  assign fwd_diff = rd_fwd_seq - rd_seq;

  // R6: read outcomes are mutually exclusive
  assert_read_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_from_rf, rd_fwd, rd_stall}));

  // R4: no read answer without a query
  assert_read_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_from_rf || rd_fwd || rd_stall) |-> rd_valid);

  // R5 / R10: forwarding producer is strictly older than the reader
  assert_fwd_older_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fwd |-> fwd_diff[SEQ_W-1]);

  // R7: no grant without a write query
  assert_grant_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> wr_valid);

  // R11: bad-index flag is sticky
  assert_bad_idx_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_bad_idx |=> err_bad_idx);

  // R8: order flag is sticky
  assert_order_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_order |=> err_order);
endmodule

bind regdep_scoreboard regdep_scoreboard_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_seq     (rd_seq),
  .rd_from_rf (rd_from_rf),
  .rd_fwd     (rd_fwd),
  .rd_fwd_seq (rd_fwd_seq),
  .rd_stall   (rd_stall),
  .wr_valid   (wr_valid),
  .wr_grant   (wr_grant),
  .err_bad_idx(err_bad_idx),
  .err_order  (err_order)
);

// File: tb/regdep_scoreboard_tb.sv
`timescale 1ns/1ps
module regdep_scoreboard_tb;
  localparam int SEQ_W = 8;
  localparam int IDX_W = 5;
  localparam int DST_N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                   disp_valid = 0;
  logic                   disp_ready;
  logic [SEQ_W-1:0]       disp_seq = 0;
  logic [DST_N-1:0]       disp_dst_en = 0;
  logic [DST_N*IDX_W-1:0] disp_dst = 0;
  logic                   done_valid = 0;
  logic [IDX_W-1:0]       done_idx = 0;
  logic [SEQ_W-1:0]       done_seq = 0;
  logic                   rd_valid = 0;
  logic [IDX_W-1:0]       rd_idx = 0;
  logic [SEQ_W-1:0]       rd_seq = 0;
  logic                   rd_from_rf, rd_fwd, rd_stall;
  logic [SEQ_W-1:0]       rd_fwd_seq;
  logic                   wr_valid = 0;
  logic [IDX_W-1:0]       wr_idx = 0;
  logic [SEQ_W-1:0]       wr_seq = 0;
  logic                   wr_grant;
  logic                   rm_valid = 0;
  logic [IDX_W-1:0]       rm_idx = 0;
  logic [SEQ_W-1:0]       rm_seq = 0;
  logic                   err_bad_idx, err_order;

  regdep_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_seq(disp_seq),
    .disp_dst_en(disp_dst_en), .disp_dst(disp_dst),
    .done_valid(done_valid), .done_idx(done_idx), .done_seq(done_seq),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_seq(rd_seq),
    .rd_from_rf(rd_from_rf), .rd_fwd(rd_fwd), .rd_fwd_seq(rd_fwd_seq), .rd_stall(rd_stall),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_seq(wr_seq), .wr_grant(wr_grant),
    .rm_valid(rm_valid), .rm_idx(rm_idx), .rm_seq(rm_seq),
    .err_bad_idx(err_bad_idx), .err_order(err_order)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expect: 0 = rf, 1 = forward (with seq), 2 = stall
  task automatic read_chk(string req, int idx, int seq, int kind, int fseq);
    rd_valid = 1; rd_idx = IDX_W'(idx); rd_seq = SEQ_W'(seq);
    #1;
    check({req, " rf"},    int'(rd_from_rf), int'(kind == 0));
    check({req, " fwd"},   int'(rd_fwd),     int'(kind == 1));
    check({req, " stall"}, int'(rd_stall),   int'(kind == 2));
    if (kind == 1) check({req, " fwd_seq"}, int'(rd_fwd_seq), fseq);
    rd_valid = 0;
  endtask

  task automatic dispatch(int d0, int d1, int en, int seq);
    disp_dst = {IDX_W'(d1), IDX_W'(d0)};
    disp_dst_en = DST_N'(en);
    disp_seq = SEQ_W'(seq);
    disp_valid = 1;
    step();
    disp_valid = 0; disp_dst_en = 0;
  endtask

  task automatic mark(int idx, int seq);
    done_valid = 1; done_idx = IDX_W'(idx); done_seq = SEQ_W'(seq);
    step();
    done_valid = 0;
  endtask

  task automatic write_chk(string req, int idx, int seq, int exp_grant);
    wr_valid = 1; wr_idx = IDX_W'(idx); wr_seq = SEQ_W'(seq);
    #1;
    check({req, " grant"}, int'(wr_grant), exp_grant);
    step();
    wr_valid = 0;
  endtask

  task automatic remove(int idx, int seq);
    rm_valid = 1; rm_idx = IDX_W'(idx); rm_seq = SEQ_W'(seq);
    step();
    rm_valid = 0;
  endtask

  task automatic t_reset();
    disp_dst_en = 2'b01; disp_dst = {IDX_W'(0), IDX_W'(3)};
    #1;
    check("R13 ready after reset", int'(disp_ready), 1);
    check("R13 err_bad_idx", int'(err_bad_idx), 0);
    check("R13 err_order", int'(err_order), 0);
    disp_dst_en = 0;
    read_chk("R13 empty read", 3, 5, 0, 0);
    #1;
    check("R4 idle outputs", int'(rd_from_rf | rd_fwd | rd_stall), 0);
  endtask

  task automatic t_dispatch_classes();
    dispatch(3, 8, 3, 10);
    read_chk("R4 older reader", 3, 5, 0, 0);
    read_chk("R6 not done", 3, 12, 2, 0);
    read_chk("R1 int0 separate", 0, 12, 0, 0);
    read_chk("R1 misc16 separate", 16, 12, 0, 0);
    read_chk("R2 lane1 fp8", 8, 12, 2, 0);
    mark(3, 10);
    read_chk("R12 forward after done", 3, 12, 1, 10);
    read_chk("R12 fp8 still stalls", 8, 12, 2, 0);
  endtask

  task automatic t_order_and_write();
    dispatch(3, 0, 1, 20);
    read_chk("R5 youngest older", 3, 15, 1, 10);
    read_chk("R6 tail not done", 3, 25, 2, 0);
    mark(3, 20);
    read_chk("R5 tail forward", 3, 25, 1, 20);
    write_chk("R7 younger than head", 3, 20, 0);
    write_chk("R7 head write", 3, 10, 1);
    read_chk("R8 head popped", 3, 15, 0, 0);
    check("R8 no order error", int'(err_order), 0);
  endtask

  task automatic t_mismatch();
    write_chk("R8 older non-head grant", 8, 5, 1);
    check("R8 err_order set", int'(err_order), 1);
    read_chk("R8 queue unchanged", 8, 12, 2, 0);
  endtask

  task automatic t_remove();
    dispatch(17, 0, 1, 30);
    dispatch(17, 0, 1, 31);
    dispatch(17, 0, 1, 32);
    remove(17, 31);
    mark(17, 30);
    mark(17, 32);
    read_chk("R9 tail kept", 17, 33, 1, 32);
    read_chk("R9 middle removed", 17, 32, 1, 30);
    remove(17, 99);
    read_chk("R9 no-match unchanged", 17, 33, 1, 32);
  endtask

  task automatic t_backpressure();
    for (int s = 40; s < 44; s++) dispatch(5, 0, 1, s);
    disp_dst = {IDX_W'(0), IDX_W'(5)}; disp_dst_en = 2'b01; disp_seq = 8'd44;
    disp_valid = 1;
    #1;
    check("R3 ready low when full", int'(disp_ready), 0);
    step();
    disp_valid = 0;
    disp_dst = {IDX_W'(0), IDX_W'(6)};
    #1;
    check("R3 other reg ready", int'(disp_ready), 1);
    disp_dst_en = 0;
    mark(5, 43);
    read_chk("R3 rejected not queued", 5, 50, 1, 43);
    dispatch(6, 6, 3, 60);
    write_chk("R2 dup head", 6, 60, 1);
    read_chk("R2 dup appended once", 6, 70, 0, 0);
  endtask

  task automatic t_wrap();
    dispatch(12, 0, 1, 250);
    mark(12, 250);
    read_chk("R10 wrapped younger reader", 12, 3, 1, 250);
    read_chk("R10 older reader", 12, 249, 0, 0);
    write_chk("R10 head write", 12, 250, 1);
    read_chk("R10 popped", 12, 3, 0, 0);
  endtask

  task automatic t_bad_idx();
    disp_dst = {IDX_W'(2), IDX_W'(25)}; disp_dst_en = 2'b11;
    #1;
    check("R11 ready with bad lane", int'(disp_ready), 1);
    dispatch(25, 2, 3, 80);
    check("R11 err_bad_idx set", int'(err_bad_idx), 1);
    read_chk("R11 no update", 2, 90, 0, 0);
    check("R11 err sticky", int'(err_bad_idx), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dispatch_classes();
    t_order_and_write();
    t_mismatch();
    t_remove();
    t_backpressure();
    t_wrap();
    t_bad_idx();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule